// File: doc/BRIEF.md
# DDR2 Command Decoder with Bank State Tracking

This block sits behind the command/address register of a DDR2 memory channel. On each rising clock edge it samples chip select, the three command strobes, the bank address and the address bus. It turns them into one registered command record: a strobe, the command type, the target bank, the row or column, and the auto-precharge and precharge-all qualifiers. For load-mode commands it also gives the mode-register index and opcode. An illegal-command pulse accompanies the record when the command is invalid.

Alongside the decode it keeps an open/closed flag and the open row for every bank. Monitors, protocol checkers and command schedulers can read the live bank map directly, without rebuilding it from the command stream. Address bit 10 is read differently by command type: it is the auto-precharge request on reads and writes, and the all-banks request on precharge. Commands are ignored entirely while chip select is high or clock enable is low.

Top module: `ddr2_cmd_tracker`

## Requirements
- R1: While chip select is sampled high, no command strobe and no illegal pulse appear, and the bank map is left unchanged.
- R2: While clock enable is sampled low, no command strobe and no illegal pulse appear, and the bank map is left unchanged.
- R3: The command record is registered and appears one cycle after the sampling edge. The type is {ras_n, cas_n, we_n}, with these codes: 0 load mode, 1 refresh, 2 precharge, 3 activate, 4 write, 5 read, 6 reserved. Code 7 (no-op) gives no strobe. With no strobe the type reads 7 and every field reads zero. A field that does not apply to the command also reads zero.
- R4: On load mode, the mode-register index equals the bank address (0 MR, 1 EMR, 2 EMR2, 3 EMR3) and the opcode equals the full address bus. The bank map is left unchanged.
- R5: An activate to a closed bank opens that bank and records address bits 12..0 as its row. The record reports the bank and the row.
- R6: On read or write, the column is address bits 9..0 and the auto-precharge flag is address bit 10. When the target bank is open and the flag is set, the bank is closed after the command.
- R7: On precharge with address bit 10 low, only the addressed bank is closed. With bit 10 high, every bank is closed and the precharge-all flag is set.
- R8: These commands raise the illegal pulse together with the strobe and leave the bank map unchanged: an activate to an open bank, a read or write to a closed bank, and the reserved code 6.
- R9: After reset every bank is closed, every row reads zero, there is no strobe, and the type reads 7.
- R10: The row field of any closed bank reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Command clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cke_i | input | 1 | Clock enable; low suppresses decoding |
| cs_ni | input | 1 | Chip select, active low |
| ras_ni | input | 1 | Row strobe, active low |
| cas_ni | input | 1 | Column strobe, active low |
| we_ni | input | 1 | Write enable, active low |
| ba_i | input | BA_W | Bank address / mode-register select |
| addr_i | input | ROW_W | Address bus |
| cmd_valid_o | output | 1 | Decoded command strobe |
| cmd_type_o | output | 3 | Command code (7 when idle) |
| cmd_bank_o | output | BA_W | Target bank |
| cmd_row_o | output | ROW_W | Row of an activate |
| cmd_col_o | output | COL_W | Column of a read or write |
| cmd_ap_o | output | 1 | Auto-precharge request |
| cmd_pre_all_o | output | 1 | Precharge of all banks |
| mr_sel_o | output | BA_W | Mode-register index on load mode |
| mr_opcode_o | output | ROW_W | Mode-register opcode |
| illegal_o | output | 1 | Illegal-command pulse |
| bank_open_o | output | 2**BA_W | Per-bank open flag |
| bank_row_o | output | 2**BA_W*ROW_W | Per-bank open row, bank 0 in the low bits |

## Verification
A wrong bank flag shows up at the latest on the next command to that bank. A stuck-open bank turns the next legal activate into an illegal pulse. A bank wrongly closed flags the next read or write. Both errors also show at once on bank_open_o, which the bench compares after every command. A lost or stale row is visible on bank_row_o one cycle after the activate or close that should have changed it. A misread address bit 10 shows in the same cycle as a wrong flag on the record and as a wrong set of closed banks.

// File: rtl/ddr2_cmd_pkg.sv
package ddr2_cmd_pkg;
  typedef enum logic [2:0] {
    OP_LOAD_MODE = 3'd0,
    OP_REFRESH   = 3'd1,
    OP_PRECHARGE = 3'd2,
    OP_ACTIVATE  = 3'd3,
    OP_WRITE     = 3'd4,
    OP_READ      = 3'd5,
    OP_RESERVED  = 3'd6,
    OP_NOP       = 3'd7
  } op_e;
endpackage

// File: rtl/ddr2_cmd_decode.sv
module ddr2_cmd_decode
  import ddr2_cmd_pkg::*;
#(
  parameter int unsigned BA_W   = 2,
  parameter int unsigned ROW_W  = 13,
  parameter int unsigned COL_W  = 10,
  parameter int unsigned AP_BIT = 10
) (
  input  logic             cke_i,
  input  logic             cs_ni,
  input  logic             ras_ni,
  input  logic             cas_ni,
  input  logic             we_ni,
  input  logic [BA_W-1:0]  ba_i,
  input  logic [ROW_W-1:0] addr_i,
  output logic             valid_o,
  output op_e              op_o,
  output logic             is_act_o,
  output logic             is_rdwr_o,
  output logic             is_pre_o,
  output logic             ap_o,
  output logic             pre_all_o,
  output logic [BA_W-1:0]  bank_o,
  output logic [ROW_W-1:0] row_o,
  output logic [COL_W-1:0] col_o,
  output logic [BA_W-1:0]  mr_sel_o,
  output logic [ROW_W-1:0] opcode_o
);
  op_e  code;
  logic live;
  logic is_mrs;

  assign code    = op_e'({ras_ni, cas_ni, we_ni});
  assign live    = cke_i & ~cs_ni & (code != OP_NOP);
  assign valid_o = live;
  assign op_o    = live ? code : OP_NOP;

  assign is_act_o  = live & (code == OP_ACTIVATE);
  assign is_rdwr_o = live & ((code == OP_READ) | (code == OP_WRITE));
  assign is_pre_o  = live & (code == OP_PRECHARGE);
  assign is_mrs    = live & (code == OP_LOAD_MODE);

  // bit AP_BIT is auto-precharge on rd/wr, all-banks on precharge
  assign ap_o      = is_rdwr_o & addr_i[AP_BIT];
  assign pre_all_o = is_pre_o & addr_i[AP_BIT];

  assign bank_o   = (is_act_o | is_rdwr_o | is_pre_o) ? ba_i : '0;
  assign row_o    = is_act_o ? addr_i : '0;
  assign col_o    = is_rdwr_o ? addr_i[COL_W-1:0] : '0;
  assign mr_sel_o = is_mrs ? ba_i : '0;
  assign opcode_o = is_mrs ? addr_i : '0;
endmodule

// File: rtl/ddr2_cmd_legality.sv
module ddr2_cmd_legality
  import ddr2_cmd_pkg::*;
#(
  parameter int unsigned BA_W      = 2,
  localparam int unsigned NUM_BANKS = 1 << BA_W
) (
  input  logic                 valid_i,
  input  op_e                  op_i,
  input  logic                 is_act_i,
  input  logic                 is_rdwr_i,
  input  logic                 is_pre_i,
  input  logic                 ap_i,
  input  logic                 pre_all_i,
  input  logic [BA_W-1:0]      bank_i,
  input  logic [NUM_BANKS-1:0] bank_open_i,
  output logic                 illegal_o,
  output logic [NUM_BANKS-1:0] set_o,
  output logic [NUM_BANKS-1:0] clr_o
);
  logic [NUM_BANKS-1:0] sel;
  logic                 tgt_open;

  for (genvar i = 0; i < NUM_BANKS; i++) begin : g_sel
    assign sel[i] = (bank_i == BA_W'(i));
  end

  assign tgt_open  = bank_open_i[bank_i];
  assign illegal_o = valid_i & ((op_i == OP_RESERVED)
                              | (is_act_i & tgt_open)
                              | (is_rdwr_i & ~tgt_open));

  always_comb begin
    set_o = '0;
    clr_o = '0;
    if (is_act_i && !tgt_open) set_o = sel;
    if (is_pre_i)              clr_o = pre_all_i ? '1 : sel;
    if (is_rdwr_i && ap_i && tgt_open) clr_o = sel;
  end
endmodule

// File: rtl/ddr2_bank_slot.sv
module ddr2_bank_slot #(
  parameter int unsigned ROW_W = 13
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             set_i,
  input  logic             clr_i,
  input  logic [ROW_W-1:0] row_i,
  output logic             open_o,
  output logic [ROW_W-1:0] row_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      open_o <= 1'b0;
      row_o  <= '0;
    end else if (set_i) begin
      open_o <= 1'b1;
      row_o  <= row_i;
    end else if (clr_i) begin
      open_o <= 1'b0;
      row_o  <= '0;
    end
  end
endmodule

// File: rtl/ddr2_cmd_tracker.sv
module ddr2_cmd_tracker
  import ddr2_cmd_pkg::*;
#(
  parameter int unsigned BA_W      = 2,
  parameter int unsigned ROW_W     = 13,
  parameter int unsigned COL_W     = 10,
  parameter int unsigned AP_BIT    = 10,
  localparam int unsigned NUM_BANKS = 1 << BA_W
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       cke_i,
  input  logic                       cs_ni,
  input  logic                       ras_ni,
  input  logic                       cas_ni,
  input  logic                       we_ni,
  input  logic [BA_W-1:0]            ba_i,
  input  logic [ROW_W-1:0]           addr_i,
  output logic                       cmd_valid_o,
  output logic [2:0]                 cmd_type_o,
  output logic [BA_W-1:0]            cmd_bank_o,
  output logic [ROW_W-1:0]           cmd_row_o,
  output logic [COL_W-1:0]           cmd_col_o,
  output logic                       cmd_ap_o,
  output logic                       cmd_pre_all_o,
  output logic [BA_W-1:0]            mr_sel_o,
  output logic [ROW_W-1:0]           mr_opcode_o,
  output logic                       illegal_o,
  output logic [NUM_BANKS-1:0]       bank_open_o,
  output logic [NUM_BANKS*ROW_W-1:0] bank_row_o
);
  logic             d_valid, d_act, d_rdwr, d_pre, d_ap, d_pre_all;
  op_e              d_op;
  logic [BA_W-1:0]  d_bank, d_mr_sel;
  logic [ROW_W-1:0] d_row, d_opcode;
  logic [COL_W-1:0] d_col;
  logic             d_illegal;
  logic [NUM_BANKS-1:0] set_vec, clr_vec;

  ddr2_cmd_decode #(
    .BA_W(BA_W), .ROW_W(ROW_W), .COL_W(COL_W), .AP_BIT(AP_BIT)
  ) u_decode (
    .cke_i    (cke_i),
    .cs_ni    (cs_ni),
    .ras_ni   (ras_ni),
    .cas_ni   (cas_ni),
    .we_ni    (we_ni),
    .ba_i     (ba_i),
    .addr_i   (addr_i),
    .valid_o  (d_valid),
    .op_o     (d_op),
    .is_act_o (d_act),
    .is_rdwr_o(d_rdwr),
    .is_pre_o (d_pre),
    .ap_o     (d_ap),
    .pre_all_o(d_pre_all),
    .bank_o   (d_bank),
    .row_o    (d_row),
    .col_o    (d_col),
    .mr_sel_o (d_mr_sel),
    .opcode_o (d_opcode)
  );

  ddr2_cmd_legality #(.BA_W(BA_W)) u_legality (
    .valid_i    (d_valid),
    .op_i       (d_op),
    .is_act_i   (d_act),
    .is_rdwr_i  (d_rdwr),
    .is_pre_i   (d_pre),
    .ap_i       (d_ap),
    .pre_all_i  (d_pre_all),
    .bank_i     (d_bank),
    .bank_open_i(bank_open_o),
    .illegal_o  (d_illegal),
    .set_o      (set_vec),
    .clr_o      (clr_vec)
  );

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    ddr2_bank_slot #(.ROW_W(ROW_W)) u_slot (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .set_i (set_vec[b]),
      .clr_i (clr_vec[b]),
      .row_i (d_row),
      .open_o(bank_open_o[b]),
      .row_o (bank_row_o[b*ROW_W +: ROW_W])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmd_valid_o   <= 1'b0;
      cmd_type_o    <= 3'(OP_NOP);
      cmd_bank_o    <= '0;
      cmd_row_o     <= '0;
      cmd_col_o     <= '0;
      cmd_ap_o      <= 1'b0;
      cmd_pre_all_o <= 1'b0;
      mr_sel_o      <= '0;
      mr_opcode_o   <= '0;
      illegal_o     <= 1'b0;
    end else begin
      cmd_valid_o   <= d_valid;
      cmd_type_o    <= 3'(d_op);
      cmd_bank_o    <= d_bank;
      cmd_row_o     <= d_row;
      cmd_col_o     <= d_col;
      cmd_ap_o      <= d_ap;
      cmd_pre_all_o <= d_pre_all;
      mr_sel_o      <= d_mr_sel;
      mr_opcode_o   <= d_opcode;
      illegal_o     <= d_illegal;
    end
  end
endmodule

// File: rtl/ddr2_cmd_tracker_chk.sv
module ddr2_cmd_tracker_chk #(
  parameter int unsigned BA_W      = 2,
  parameter int unsigned ROW_W     = 13,
  parameter int unsigned COL_W     = 10,
  localparam int unsigned NUM_BANKS = 1 << BA_W
) (
  input logic                       clk_i,
  input logic                       rst_ni,
  input logic                       cke_i,
  input logic                       cs_ni,
  input logic                       cmd_valid_o,
  input logic [2:0]                 cmd_type_o,
  input logic [BA_W-1:0]            cmd_bank_o,
  input logic [ROW_W-1:0]           cmd_row_o,
  input logic                       cmd_ap_o,
  input logic                       cmd_pre_all_o,
  input logic                       illegal_o,
  input logic [NUM_BANKS-1:0]       bank_open_o,
  input logic [NUM_BANKS*ROW_W-1:0] bank_row_o
);
  a_r1_cs_masks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_ni |=> (!cmd_valid_o && !illegal_o && bank_open_o == $past(bank_open_o)));

  a_r2_cke_masks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cke_i |=> (!cmd_valid_o && !illegal_o && bank_open_o == $past(bank_open_o)));

  a_r5_act_opens: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_o && cmd_type_o == 3'd3) |-> bank_open_o[cmd_bank_o]);

  a_r5_act_row: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_o && cmd_type_o == 3'd3 && !illegal_o)
      |-> bank_row_o[cmd_bank_o*ROW_W +: ROW_W] == cmd_row_o);

  a_r6_ap_closes: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_o && (cmd_type_o == 3'd4 || cmd_type_o == 3'd5) && cmd_ap_o)
      |-> !bank_open_o[cmd_bank_o]);

  a_r7_pre_all: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_o && cmd_type_o == 3'd2 && cmd_pre_all_o) |-> bank_open_o == '0);

  a_r8_illegal_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    illegal_o |-> cmd_valid_o);

  a_r8_illegal_keeps: assert property (@(posedge clk_i) disable iff (!rst_ni)
    illegal_o |-> bank_open_o == $past(bank_open_o));

  a_r3_idle_type: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cmd_valid_o |-> cmd_type_o == 3'd7);

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_row
    a_r10_closed_row_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !bank_open_o[b] |-> bank_row_o[b*ROW_W +: ROW_W] == '0);
  end
endmodule

bind ddr2_cmd_tracker ddr2_cmd_tracker_chk #(
  .BA_W(BA_W), .ROW_W(ROW_W), .COL_W(COL_W)
) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .cke_i        (cke_i),
  .cs_ni        (cs_ni),
  .cmd_valid_o  (cmd_valid_o),
  .cmd_type_o   (cmd_type_o),
  .cmd_bank_o   (cmd_bank_o),
  .cmd_row_o    (cmd_row_o),
  .cmd_ap_o     (cmd_ap_o),
  .cmd_pre_all_o(cmd_pre_all_o),
  .illegal_o    (illegal_o),
  .bank_open_o  (bank_open_o),
  .bank_row_o   (bank_row_o)
);

// File: tb/ddr2_cmd_tracker_bench.sv
module ddr2_cmd_tracker_bench;
  localparam int BA_W = 2;
  localparam int ROW_W = 13;
  localparam int COL_W = 10;
  localparam int NB = 4;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic cke, cs_n, ras_n, cas_n, we_n;
  logic [BA_W-1:0] ba;
  logic [ROW_W-1:0] addr;
  logic cmd_valid, cmd_ap, cmd_pre_all, illegal;
  logic [2:0] cmd_type;
  logic [BA_W-1:0] cmd_bank, mr_sel;
  logic [ROW_W-1:0] cmd_row, mr_opcode;
  logic [COL_W-1:0] cmd_col;
  logic [NB-1:0] bank_open;
  logic [NB*ROW_W-1:0] bank_row;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 0;

  logic [NB-1:0] m_open;
  logic [ROW_W-1:0] m_row [NB];

  always #2 clk = ~clk;

  ddr2_cmd_tracker u_ddr2_cmd_tracker (
    .clk_i(clk), .rst_ni(rst_ni), .cke_i(cke), .cs_ni(cs_n),
    .ras_ni(ras_n), .cas_ni(cas_n), .we_ni(we_n), .ba_i(ba), .addr_i(addr),
    .cmd_valid_o(cmd_valid), .cmd_type_o(cmd_type), .cmd_bank_o(cmd_bank),
    .cmd_row_o(cmd_row), .cmd_col_o(cmd_col), .cmd_ap_o(cmd_ap),
    .cmd_pre_all_o(cmd_pre_all), .mr_sel_o(mr_sel), .mr_opcode_o(mr_opcode),
    .illegal_o(illegal), .bank_open_o(bank_open), .bank_row_o(bank_row)
  );

  task automatic check(string tag, string what, logic [63:0] got, logic [63:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, got, exp);
    end
  endtask

  function automatic logic [NB*ROW_W-1:0] model_rows();
    logic [NB*ROW_W-1:0] r;
    for (int b = 0; b < NB; b++) r[b*ROW_W +: ROW_W] = m_row[b];
    return r;
  endfunction

  // drive at negedge, outputs registered at next posedge, sampled at following negedge
  task automatic issue(bit k, bit cs, logic [2:0] code, logic [1:0] b, logic [12:0] a);
    bit live, ill, rdwr;
    string tag;
    logic [2:0] e_type;
    logic [1:0] e_bank, e_mr;
    logic [12:0] e_row, e_op;
    logic [9:0] e_col;
    bit e_ap, e_pa;
    cke = k; cs_n = cs; {ras_n, cas_n, we_n} = code; ba = b; addr = a;
    live = k && !cs && code != 3'd7;
    rdwr = (code == 3'd4 || code == 3'd5);
    ill = live && (code == 3'd6 || (code == 3'd3 && m_open[b]) || (rdwr && !m_open[b]));
    e_type = live ? code : 3'd7;
    e_bank = (live && code >= 3'd2 && code <= 3'd5) ? b : 2'd0;
    e_row  = (live && code == 3'd3) ? a : 13'd0;
    e_col  = (live && rdwr) ? a[9:0] : 10'd0;
    e_ap   = live && rdwr && a[10];
    e_pa   = live && code == 3'd2 && a[10];
    e_mr   = (live && code == 3'd0) ? b : 2'd0;
    e_op   = (live && code == 3'd0) ? a : 13'd0;
    if (cs) tag = "R1";
    else if (!k) tag = "R2";
    else if (ill) tag = "R8";
    else case (code)
      3'd0: tag = "R4";
      3'd3: tag = "R5";
      3'd2: tag = "R7";
      3'd4, 3'd5: tag = "R6";
      default: tag = "R3";
    endcase
    if (live && !ill) begin
      case (code)
        3'd3: begin m_open[b] = 1'b1; m_row[b] = a; end
        3'd2: begin
          if (a[10]) begin
            m_open = '0;
            for (int i = 0; i < NB; i++) m_row[i] = '0;
          end else begin
            m_open[b] = 1'b0; m_row[b] = '0;
          end
        end
        3'd4, 3'd5: if (a[10]) begin m_open[b] = 1'b0; m_row[b] = '0; end
        default: ;
      endcase
    end
    @(posedge clk);
    @(negedge clk);
    check(tag, "strobe/type/illegal", {cmd_valid, cmd_type, illegal}, {live, e_type, ill});
    check(tag, "fields", {cmd_bank, cmd_row, cmd_col, cmd_ap, cmd_pre_all, mr_sel, mr_opcode},
          {e_bank, e_row, e_col, e_ap, e_pa, e_mr, e_op});
    check(tag, "bank_open", 64'(bank_open), 64'(m_open));
    check("R10", "bank_row", 64'(bank_row), 64'(model_rows()));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_2d2));
    cke = 1'b1; cs_n = 1'b1; {ras_n, cas_n, we_n} = 3'b111; ba = '0; addr = '0;
    m_open = '0;
    for (int i = 0; i < NB; i++) m_row[i] = '0;
    repeat (3) @(negedge clk);
    check("R9", "reset strobe/type", {cmd_valid, cmd_type, illegal}, {1'b0, 3'd7, 1'b0});
    check("R9", "reset bank_open", 64'(bank_open), 64'd0);
    check("R9", "reset bank_row", 64'(bank_row), 64'd0);
    rst_ni = 1'b1;
    @(negedge clk);

    // directed corners
    for (int r = 0; r < 4; r++) issue(1, 0, 3'd0, 2'(r), 13'h1A5 + 13'(r));  // R4 each register
    issue(1, 0, 3'd3, 2'd0, 13'h1ABC);   // R5 open bank 0
    issue(1, 0, 3'd3, 2'd0, 13'h0123);   // R8 activate to open bank
    issue(1, 0, 3'd5, 2'd1, 13'h0010);   // R8 read to closed bank
    issue(1, 0, 3'd4, 2'd0, 13'h0455);   // R6 write with auto-precharge closes bank 0
    issue(1, 0, 3'd3, 2'd0, 13'h0001);
    issue(1, 0, 3'd3, 2'd1, 13'h1FFF);
    issue(1, 0, 3'd3, 2'd2, 13'h0800);
    issue(1, 0, 3'd5, 2'd2, 13'h03FF);   // R6 read without auto-precharge
    issue(1, 0, 3'd2, 2'd1, 13'h0000);   // R7 single-bank precharge
    issue(1, 1, 3'd3, 2'd3, 13'h0777);   // R1 masked activate
    issue(0, 0, 3'd3, 2'd3, 13'h0777);   // R2 masked activate
    issue(1, 0, 3'd6, 2'd0, 13'h0000);   // R8 reserved code
    issue(1, 0, 3'd7, 2'd2, 13'h1234);   // R3 no-op
    issue(1, 0, 3'd1, 2'd0, 13'h0000);   // R3 refresh
    issue(1, 0, 3'd2, 2'd3, 13'h0400);   // R7 precharge all
    issue(1, 0, 3'd5, 2'd0, 13'h0400);   // R8 read+ap to closed bank

    for (int n = 0; n < 4000; n++) begin
      int p;
      bit k, cs;
      logic [2:0] code;
      p = int'($urandom_range(99));
      k = (p >= 5);
      cs = (p >= 5 && p < 15);
      code = 3'($urandom_range(7));
      if ($urandom_range(3) == 0) code = 3'd3;
      issue(k, cs, code, 2'($urandom_range(3)), 13'($urandom));
    end

    done = 1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule